// File: doc/BRIEF.md
# Counter Interrupt Hub

This block gathers the event activity of a group of counter channels into a single interrupt line and a small set of host-visible byte registers. Each channel presents four event pulses: carry, borrow, compare and index. A per-channel 2-bit trigger code picks which of these can raise that channel's interrupt. A per-channel mask bit then gates the selected event. A global interrupt-function switch gates it as well. A gated event sets that channel's bit in a sticky pending register. The shared interrupt output is high whenever any pending bit is set.

The host reaches the block through a plain byte register port with an address, a write strobe, write data and combinational read data. A write to the operation register either stops the channels, which pulses a counter-clear output and turns the interrupt function off, or starts them, which turns the function on and empties the pending register in the same write. Two more registers report what the channel pins show: the registered index input levels, and the cable health of each channel. Cable health has active-low enables and active-low fault reporting.

Top module: `ctr_irq_hub`

## Requirements
- R1: After reset the pending register (address 0) reads 0x00 and `irq` is low. `countEnable` is low, so the interrupt function is off. The mask (address 2) reads 0x00, every trigger code (addresses 5 and 6) is 0, and every cable detector is disabled, so address 4 reads 0xFF.
- R2: While the function is on, an event on channel n whose trigger code selects it, and whose mask bit n (address 2) is 1, sets pending bit n at the next clock edge. The pending register reads back at address 0.
- R3: An event on a channel whose mask bit is 0, or any event while the function is off, leaves the pending register unchanged.
- R4: `irq` is high exactly when at least one pending bit is set. A pending bit stays set when its mask bit is later cleared. It is cleared only by a start write.
- R5: A write to address 1 with bit 2 set and bit 0 clear (0x04) sets `countEnable` and clears every pending bit. An event that is enabled in that same cycle stays pending.
- R6: A write to address 1 with bit 0 set (0x01) clears `countEnable` and raises `counterClr` for exactly the following cycle. Bit 0 takes precedence over bit 2, and the write does not change the pending register.
- R7: Each channel has a 2-bit trigger code: 0 selects carry, 1 selects compare, 2 selects carry or borrow, and 3 selects index. Channel n's code sits at address 5 + n/4, in bits [2(n%4)+1 : 2(n%4)], and reads back from the same place.
- R8: Address 3 reads the index input levels, bit n for channel n, one clock edge after they are applied.
- R9: A write to address 4 sets the cable enables, where a 0 in bit n enables detection on channel n. A read of address 4 returns 0 in bit n only when detection is enabled and `cableOk[n]` is low (a fault). Disabled channels read 1.
- R10: Writes to address 0 have no effect on the pending register or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| carryEv | input | 8 | Carry event pulse, one bit per channel |
| borrowEv | input | 8 | Borrow event pulse, one bit per channel |
| compareEv | input | 8 | Compare event pulse, one bit per channel |
| indexEv | input | 8 | Index event pulse, one bit per channel |
| idxLvl | input | 8 | Index input logic levels |
| cableOk | input | 8 | Cable health per channel, low means fault |
| irq | output | 1 | Shared interrupt, high while any bit is pending |
| countEnable | output | 1 | Counting and interrupt function enabled |
| counterClr | output | 1 | One-cycle pulse that clears all counters |

## Verification
The bench drives each event type on all channels at once, after loading trigger codes that differ per channel, so each pending pattern names the channels whose code selects that event. Carry-only, borrow-only, compare-only and index-only pulses give four different patterns, which separates the carry-or-borrow code from the plain carry code. Events are also sent with the mask cleared, with the function off, and in the same cycle as a start write. These three cases separate gating by the mask, gating by the function switch, and the order between clearing and setting. Cable inputs mix enabled and disabled channels with healthy and faulty cables, so every combination of enable and fault shows up in a single read.

// File: rtl/ctr_irq_pkg.sv
package ctr_irq_pkg;

  // register addresses
  localparam int A_PEND  = 0;
  localparam int A_OPER  = 1;
  localparam int A_MASK  = 2;
  localparam int A_LEVEL = 3;
  localparam int A_CABLE = 4;
  localparam int A_SEL0  = 5;

  // operation register bits
  localparam int OP_STOP_BIT = 0;
  localparam int OP_RUN_BIT  = 2;

  typedef enum logic [1:0] {
    TRIG_CARRY   = 2'd0,
    TRIG_COMPARE = 2'd1,
    TRIG_WRAP    = 2'd2,
    TRIG_INDEX   = 2'd3
  } trig_t;

  typedef struct packed {
    logic       wrMask;
    logic       wrCable;
    logic       wrSel;
    logic [2:0] selBank;
    logic       opRun;
    logic       opStop;
  } strobes_t;

endpackage

// File: rtl/ctr_irq_ctrl.sv
module ctr_irq_ctrl
  import ctr_irq_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8,
  parameter int SEL_BANKS = 2
) (
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output strobes_t      st
);

  logic operHit;
  int   bankIdx;

  assign operHit = wrEn && (addr == AW'(A_OPER));

  always_comb begin
    bankIdx    = int'(addr) - A_SEL0;
    st         = '0;
    st.wrMask  = wrEn && (addr == AW'(A_MASK));
    st.wrCable = wrEn && (addr == AW'(A_CABLE));
    st.wrSel   = wrEn && (bankIdx >= 0) && (bankIdx < SEL_BANKS);
    st.selBank = 3'(bankIdx);
    st.opStop  = operHit && wrData[OP_STOP_BIT];
    st.opRun   = operHit && wrData[OP_RUN_BIT] && !wrData[OP_STOP_BIT];
  end

endmodule

// File: rtl/ctr_irq_datapath.sv
module ctr_irq_datapath
  import ctr_irq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobes_t       st,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wrData,
  input  logic [NCH-1:0] carryEv,
  input  logic [NCH-1:0] borrowEv,
  input  logic [NCH-1:0] compareEv,
  input  logic [NCH-1:0] indexEv,
  input  logic [NCH-1:0] idxLvl,
  input  logic [NCH-1:0] cableOk,
  output logic [DW-1:0]  rdData,
  output logic [NCH-1:0] pend,
  output logic           funcEn,
  output logic           counterClr
);

  localparam int LANES     = DW / 2;
  localparam int SEL_BANKS = (NCH + LANES - 1) / LANES;

  logic [NCH-1:0] mask;
  logic [NCH-1:0] cableEnN;
  logic [NCH-1:0] lvlReg;
  logic [NCH-1:0] okReg;
  logic [NCH-1:0] evRaw;
  logic [NCH-1:0] evGated;
  trig_t          trigSel [NCH];

  // per-channel trigger select and event mux
  for (genvar n = 0; n < NCH; n++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        trigSel[n] <= TRIG_CARRY;
      else if (st.wrSel && (int'(st.selBank) == n / LANES))
        trigSel[n] <= trig_t'(wrData[2*(n%LANES) +: 2]);
    end

    always_comb begin
      unique case (trigSel[n])
        TRIG_CARRY:   evRaw[n] = carryEv[n];
        TRIG_COMPARE: evRaw[n] = compareEv[n];
        TRIG_WRAP:    evRaw[n] = carryEv[n] | borrowEv[n];
        TRIG_INDEX:   evRaw[n] = indexEv[n];
        default:      evRaw[n] = 1'b0;
      endcase
    end
  end

  assign evGated = evRaw & mask & {NCH{funcEn}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend       <= '0;
      funcEn     <= 1'b0;
      counterClr <= 1'b0;
      mask       <= '0;
      cableEnN   <= '1;
      lvlReg     <= '0;
      okReg      <= '1;
    end else begin
      pend       <= (st.opRun ? '0 : pend) | evGated;
      counterClr <= st.opStop;
      lvlReg     <= idxLvl;
      okReg      <= cableOk;
      if (st.opStop)
        funcEn <= 1'b0;
      else if (st.opRun)
        funcEn <= 1'b1;
      if (st.wrMask)
        mask <= wrData[NCH-1:0];
      if (st.wrCable)
        cableEnN <= wrData[NCH-1:0];
    end
  end

  // read mux
  always_comb begin
    int bank;
    bank   = int'(addr) - A_SEL0;
    rdData = '0;
    if (addr == AW'(A_PEND))
      rdData = DW'(pend);
    else if (addr == AW'(A_MASK))
      rdData = DW'(mask);
    else if (addr == AW'(A_LEVEL))
      rdData = DW'(lvlReg);
    else if (addr == AW'(A_CABLE))
      rdData = DW'(cableEnN | okReg) | ~DW'({NCH{1'b1}});
    else if (bank >= 0 && bank < SEL_BANKS) begin
      for (int n = 0; n < NCH; n++)
        if (n / LANES == bank)
          rdData[2*(n%LANES) +: 2] = trigSel[n];
    end
  end

endmodule

// File: rtl/ctr_irq_hub.sv
module ctr_irq_hub
  import ctr_irq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wrData,
  output logic [DW-1:0]  rdData,
  input  logic [NCH-1:0] carryEv,
  input  logic [NCH-1:0] borrowEv,
  input  logic [NCH-1:0] compareEv,
  input  logic [NCH-1:0] indexEv,
  input  logic [NCH-1:0] idxLvl,
  input  logic [NCH-1:0] cableOk,
  output logic           irq,
  output logic           countEnable,
  output logic           counterClr
);

  localparam int LANES     = DW / 2;
  localparam int SEL_BANKS = (NCH + LANES - 1) / LANES;

  strobes_t       st;
  logic [NCH-1:0] pend;

  ctr_irq_ctrl #(.AW(AW), .DW(DW), .SEL_BANKS(SEL_BANKS)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .st(st)
  );

  ctr_irq_datapath #(.NCH(NCH), .AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .addr(addr), .wrData(wrData),
    .carryEv(carryEv), .borrowEv(borrowEv), .compareEv(compareEv),
    .indexEv(indexEv), .idxLvl(idxLvl), .cableOk(cableOk),
    .rdData(rdData), .pend(pend), .funcEn(countEnable),
    .counterClr(counterClr)
  );

  assign irq = |pend;

endmodule

// File: rtl/ctr_irq_hub_chk.sv
module ctr_irq_hub_chk
  import ctr_irq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW = 3,
  parameter int DW = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           wrEn,
  input logic [AW-1:0]  addr,
  input logic [DW-1:0]  wrData,
  input logic [NCH-1:0] carryEv,
  input logic [NCH-1:0] borrowEv,
  input logic [NCH-1:0] compareEv,
  input logic [NCH-1:0] indexEv,
  input logic           irq,
  input logic           countEnable,
  input logic           counterClr
);

  logic runWr, stopWr, anyEv;
  assign runWr  = wrEn && addr == AW'(A_OPER) && wrData[OP_RUN_BIT] && !wrData[OP_STOP_BIT];
  assign stopWr = wrEn && addr == AW'(A_OPER) && wrData[OP_STOP_BIT];
  assign anyEv  = |(carryEv | borrowEv | compareEv | indexEv);

  // R5
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runWr && !anyEv) |=> !irq);

  // R6
  stop_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> (counterClr && !countEnable));

  // R6
  clr_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    counterClr |-> $past(stopWr));

  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !runWr) |=> irq);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!countEnable && !irq) |=> !irq);

endmodule

bind ctr_irq_hub ctr_irq_hub_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .carryEv(carryEv), .borrowEv(borrowEv), .compareEv(compareEv),
  .indexEv(indexEv), .irq(irq), .countEnable(countEnable),
  .counterClr(counterClr)
);

// File: tb/ctr_irq_hub_test.sv
module ctr_irq_hub_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] carryEv = '0, borrowEv = '0, compareEv = '0, indexEv = '0;
  logic [7:0] idxLvl = '0, cableOk = '0;
  logic       irq, countEnable, counterClr;

  int nTests = 0;
  int nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ctr_irq_hub uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .carryEv(carryEv), .borrowEv(borrowEv),
    .compareEv(compareEv), .indexEv(indexEv), .idxLvl(idxLvl),
    .cableOk(cableOk), .irq(irq), .countEnable(countEnable),
    .counterClr(counterClr)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  task automatic pulse(logic [7:0] c, logic [7:0] b, logic [7:0] m, logic [7:0] i);
    @(negedge clk);
    carryEv = c; borrowEv = b; compareEv = m; indexEv = i;
    @(negedge clk);
    carryEv = '0; borrowEv = '0; compareEv = '0; indexEv = '0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(3'd0, v); check("R1 pending", v, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 countEnable", {7'b0, countEnable}, 8'h00);
    rd(3'd2, v); check("R1 mask", v, 8'h00);
    rd(3'd4, v); check("R1 cable disabled", v, 8'hFF);
    rd(3'd5, v); check("R1 sel bank0", v, 8'h00);
    rd(3'd6, v); check("R1 sel bank1", v, 8'h00);
  endtask

  task automatic t_gating;
    logic [7:0] v;
    wr(3'd2, 8'hFF);
    pulse(8'hFF, 8'h00, 8'h00, 8'h00);
    rd(3'd0, v); check("R3 function off ignores events", v, 8'h00);
    wr(3'd1, 8'h04);
    check("R5 countEnable set", {7'b0, countEnable}, 8'h01);
    wr(3'd2, 8'h0F);
    pulse(8'hFF, 8'h00, 8'h00, 8'h00);
    rd(3'd0, v); check("R2 R3 masked pending", v, 8'h0F);
    check("R4 irq high", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_sticky;
    logic [7:0] v;
    wr(3'd2, 8'h00);
    rd(3'd0, v); check("R4 pending held after mask drop", v, 8'h0F);
    check("R4 irq held", {7'b0, irq}, 8'h01);
    wr(3'd1, 8'h04);
    rd(3'd0, v); check("R5 clear", v, 8'h00);
    check("R4 irq low after clear", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_sameclr;
    logic [7:0] v;
    wr(3'd2, 8'hFF);
    pulse(8'h30, 8'h00, 8'h00, 8'h00);
    @(negedge clk);
    addr = 3'd1; wrData = 8'h04; wrEn = 1'b1; carryEv = 8'h08;
    @(negedge clk);
    wrEn = 1'b0; carryEv = '0;
    rd(3'd0, v); check("R5 same-cycle event kept", v, 8'h08);
  endtask

  task automatic t_stop;
    logic [7:0] v;
    wr(3'd1, 8'h01);
    check("R6 counterClr pulse", {7'b0, counterClr}, 8'h01);
    check("R6 countEnable low", {7'b0, countEnable}, 8'h00);
    rd(3'd0, v); check("R6 pending kept", v, 8'h08);
    @(negedge clk);
    check("R6 counterClr one cycle", {7'b0, counterClr}, 8'h00);
    pulse(8'hFF, 8'h00, 8'h00, 8'h00);
    rd(3'd0, v); check("R3 stopped ignores events", v, 8'h08);
    wr(3'd1, 8'h05);
    check("R6 stop bit wins", {7'b0, countEnable}, 8'h00);
    rd(3'd0, v); check("R6 no clear on stop", v, 8'h08);
    wr(3'd1, 8'h04);
    check("R5 restart", {7'b0, countEnable}, 8'h01);
    rd(3'd0, v); check("R5 restart clears", v, 8'h00);
  endtask

  task automatic t_select;
    logic [7:0] v;
    wr(3'd5, 8'hE4);
    wr(3'd6, 8'hAA);
    rd(3'd5, v); check("R7 bank0 readback", v, 8'hE4);
    rd(3'd6, v); check("R7 bank1 readback", v, 8'hAA);
    pulse(8'h00, 8'h00, 8'hFF, 8'h00);
    rd(3'd0, v); check("R7 compare code", v, 8'h02);
    wr(3'd1, 8'h04);
    pulse(8'h00, 8'hFF, 8'h00, 8'h00);
    rd(3'd0, v); check("R7 borrow via wrap code", v, 8'hF4);
    wr(3'd1, 8'h04);
    pulse(8'h00, 8'h00, 8'h00, 8'hFF);
    rd(3'd0, v); check("R7 index code", v, 8'h08);
    wr(3'd1, 8'h04);
    pulse(8'hFF, 8'h00, 8'h00, 8'h00);
    rd(3'd0, v); check("R7 carry codes", v, 8'hF5);
    wr(3'd1, 8'h04);
  endtask

  task automatic t_level;
    logic [7:0] v;
    @(negedge clk);
    idxLvl = 8'hA5;
    @(negedge clk);
    rd(3'd3, v); check("R8 level", v, 8'hA5);
    idxLvl = 8'h3C;
    rd(3'd3, v); check("R8 level registered", v, 8'hA5);
    @(negedge clk);
    rd(3'd3, v); check("R8 level update", v, 8'h3C);
  endtask

  task automatic t_cable;
    logic [7:0] v;
    cableOk = 8'h0F;
    wr(3'd4, 8'h33);
    rd(3'd4, v); check("R9 cable mix", v, 8'h3F);
    wr(3'd4, 8'hFF);
    rd(3'd4, v); check("R9 cable all disabled", v, 8'hFF);
  endtask

  task automatic t_pendwrite;
    logic [7:0] v;
    wr(3'd0, 8'hFF);
    rd(3'd0, v); check("R10 write ignored empty", v, 8'h00);
    check("R10 irq low", {7'b0, irq}, 8'h00);
    pulse(8'h00, 8'h00, 8'h02, 8'h00);
    wr(3'd0, 8'h00);
    rd(3'd0, v); check("R10 write ignored set", v, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_gating();
    t_sticky();
    t_sameclr();
    t_stop();
    t_select();
    t_level();
    t_cable();
    t_pendwrite();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule